// File: doc/BRIEF.md
# Digit-Sliced Constant Coefficient Multiplier

This block multiplies a stream of 16-bit two's-complement fractions by a coefficient that changes only rarely. It has no general-purpose multiplier. The coefficient is loaded through a dedicated port. A table of its sixteen digit multiples is then filled by repeated addition. Each incoming data word is split into four 4-bit digits, and each digit picks its partial product from that table. The lowest three digits are unsigned. The top digit carries the sign, so it reads the table through a signed view.

The four partial products are aligned by their digit weight and added at full precision. The exact Q2.30 product is then rounded to Q1.15 by adding half an output LSB and shifting. Results that fall outside the Q1.15 range are clamped to the nearest limit. A new word can enter every cycle once the table is complete, and its result appears three cycles later.

A typical user is a transform butterfly or a fixed-tap filter stage. It loads a coefficient, waits for the busy flag to clear, and then streams samples.

Top module: `slice_const_mul`

## Requirements
- R1: After reset `busy` and `out_valid` are 0. Until a coefficient is loaded, the table holds zeros, so every accepted word yields a product of 0x0000.
- R2: A one-cycle `coef_load` pulse makes `busy` go high in the next cycle. `busy` then stays high for exactly 16 cycles and returns to 0.
- R3: A word presented with `in_valid` high while `busy` is high is dropped. No `out_valid` pulse is ever produced for it.
- R4: A word accepted in cycle t (`in_valid`=1, `busy`=0) gives `out_valid`=1 in cycle t+3. Back-to-back words give back-to-back results in the same order.
- R5: `out_prod` equals floor((d·c + 2^14) / 2^15). Here d and c are the signed 16-bit integer values of `in_data` and the loaded coefficient.
- R6: Bits [15:12] of `in_data` form a signed digit worth −8…+7 in units of 2^12. Bits [11:0] form three unsigned digits. Negative data words, including 0x8000 and 0xFFFF, therefore give correctly signed products.
- R7: A rounded result above 32767 is output as 0x7FFF, so 0x8000 × 0x8000 gives 0x7FFF.
- R8: A `coef_load` pulse while `busy` is high restarts the fill with the new coefficient. `busy` then stays high for 16 cycles after that pulse, and later products use the new coefficient.
- R9: While `out_valid` is 0, `out_prod` keeps the value of the most recent result.
- R10: A word accepted in the same cycle as a `coef_load` pulse is multiplied by the coefficient that was in force before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_load | input | 1 | One-cycle pulse that captures `coef_in` and starts the table fill |
| coef_in | input | 16 | Coefficient, Q1.15 two's complement |
| busy | output | 1 | High while the digit table is being filled |
| in_valid | input | 1 | Data word present |
| in_data | input | 16 | Data word, Q1.15 two's complement |
| out_valid | output | 1 | Result present |
| out_prod | output | 16 | Rounded and clamped Q1.15 product |

## Verification
A single wrong table entry shows up only for words that contain that digit value. A bad entry under the signed view affects only words with the top bit set. The stimulus therefore covers every digit value in every position under several coefficients, and each result is compared three cycles after its word enters. A fill that stops early or runs too long shows directly in the length of `busy`. A stale coefficient shows up in the first product after a reload. A rounding or clamp fault shows up on the extreme operands in the same cycle they leave the pipeline.

// File: rtl/slc_pkg.sv
package slc_pkg;
   // Default geometry shared by the block and its checker
   localparam int SLC_DATA_W = 16;
   localparam int SLC_COEF_W = 16;
   localparam int SLC_DIG_W  = 4;

   // Table fill state
   typedef enum logic [0:0] {
      FILL_IDLE = 1'b0,
      FILL_RUN  = 1'b1
   } fill_state_t;
endpackage

// File: rtl/slc_table_fill.sv
module slc_table_fill
   import slc_pkg::*;
#(
   parameter int COEF_W = SLC_COEF_W,
   parameter int DIG_W  = SLC_DIG_W,
   localparam int TBL_N = 1 << DIG_W,
   localparam int PP_W  = COEF_W + DIG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     coef_load,
   input  logic [COEF_W-1:0]        coef_in,
   output logic                     busy,
   output logic [COEF_W-1:0]        coef_q,
   output logic signed [PP_W-1:0]   tbl [TBL_N]
);
   fill_state_t             state;
   logic [DIG_W-1:0]        idx;
   logic signed [PP_W-1:0]  acc;
   logic signed [PP_W-1:0]  coef_ext;

   assign coef_ext = {{DIG_W{coef_q[COEF_W-1]}}, coef_q};
   assign busy     = (state == FILL_RUN);

   // Entry i holds i * coefficient, formed by one addition per cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FILL_IDLE;
         idx    <= '0;
         acc    <= '0;
         coef_q <= '0;
         for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
      end else if (coef_load) begin
         state  <= FILL_RUN;
         coef_q <= coef_in;
         idx    <= '0;
         acc    <= '0;
      end else if (state == FILL_RUN) begin
         tbl[idx] <= acc;
         acc      <= acc + coef_ext;
         idx      <= idx + 1'b1;
         if (idx == DIG_W'(TBL_N - 1)) state <= FILL_IDLE;
      end
   end
endmodule

// File: rtl/slc_digit_lut.sv
module slc_digit_lut
   import slc_pkg::*;
#(
   parameter int DATA_W  = SLC_DATA_W,
   parameter int COEF_W  = SLC_COEF_W,
   parameter int DIG_W   = SLC_DIG_W,
   localparam int NUM_DIG = DATA_W / DIG_W,
   localparam int TBL_N   = 1 << DIG_W,
   localparam int PP_W    = COEF_W + DIG_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              accept,
   input  logic [DATA_W-1:0]                 in_data,
   input  logic [COEF_W-1:0]                 coef_q,
   input  logic signed [PP_W-1:0]            tbl [TBL_N],
   output logic                              pp_valid,
   output logic [NUM_DIG-1:0][PP_W-1:0]      pp
);
   logic [NUM_DIG-1:0][PP_W-1:0] pp_d;
   logic signed [PP_W-1:0]       coef_x16;

   // TBL_N times the coefficient: the step from unsigned to signed digit view
   assign coef_x16 = {coef_q, {DIG_W{1'b0}}};

   for (genvar k = 0; k < NUM_DIG; k++) begin : g_dig
      logic [DIG_W-1:0] dig;
      assign dig = in_data[k*DIG_W +: DIG_W];
      if (k == NUM_DIG - 1) begin : g_signed
         // Top digit: MSB weighs -2^(DIG_W-1), so value = dig - TBL_N when MSB set
         assign pp_d[k] = dig[DIG_W-1] ? (tbl[dig] - coef_x16) : tbl[dig];
      end else begin : g_unsigned
         assign pp_d[k] = tbl[dig];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_valid <= 1'b0;
         pp       <= '0;
      end else begin
         pp_valid <= accept;
         if (accept) pp <= pp_d;
      end
   end
endmodule

// File: rtl/slc_sum_round.sv
module slc_sum_round
   import slc_pkg::*;
#(
   parameter int DATA_W  = SLC_DATA_W,
   parameter int COEF_W  = SLC_COEF_W,
   parameter int DIG_W   = SLC_DIG_W,
   localparam int NUM_DIG = DATA_W / DIG_W,
   localparam int PP_W    = COEF_W + DIG_W,
   localparam int PROD_W  = DATA_W + COEF_W,
   localparam int SH      = COEF_W - 1,
   localparam int RND_W   = PROD_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pp_valid,
   input  logic [NUM_DIG-1:0][PP_W-1:0]  pp,
   output logic                          out_valid,
   output logic [DATA_W-1:0]             out_prod
);
   localparam logic signed [RND_W-1:0] HALF = RND_W'(1) <<< (SH - 1);
   localparam logic signed [RND_W-1:0] MAXV = RND_W'((1 << (DATA_W - 1)) - 1);
   localparam logic signed [RND_W-1:0] MINV = -(RND_W'(1) <<< (DATA_W - 1));

   logic signed [PROD_W-1:0] sum_d, sum_q;
   logic                     sum_valid;
   logic signed [RND_W-1:0]  rnd, quo;
   logic [DATA_W-1:0]        sat;

   // Stage 2: weight each partial product by its digit position and add
   always_comb begin
      sum_d = '0;
      for (int k = 0; k < NUM_DIG; k++) begin
         sum_d = sum_d + ({{(PROD_W-PP_W){pp[k][PP_W-1]}}, pp[k]} << (k * DIG_W));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_valid <= 1'b0;
         sum_q     <= '0;
      end else begin
         sum_valid <= pp_valid;
         if (pp_valid) sum_q <= sum_d;
      end
   end

   // Stage 3: add half an output LSB, shift, clamp
   assign rnd = {sum_q[PROD_W-1], sum_q} + HALF;
   assign quo = rnd >>> SH;

   always_comb begin
      if (quo > MAXV)      sat = MAXV[DATA_W-1:0];
      else if (quo < MINV) sat = MINV[DATA_W-1:0];
      else                 sat = quo[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_prod  <= '0;
      end else begin
         out_valid <= sum_valid;
         if (sum_valid) out_prod <= sat;
      end
   end
endmodule

// File: rtl/slice_const_mul.sv
module slice_const_mul
   import slc_pkg::*;
#(
   parameter int DATA_W = SLC_DATA_W,
   parameter int COEF_W = SLC_COEF_W,
   parameter int DIG_W  = SLC_DIG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_load,
   input  logic [COEF_W-1:0] coef_in,
   output logic              busy,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_prod
);
   localparam int NUM_DIG = DATA_W / DIG_W;
   localparam int TBL_N   = 1 << DIG_W;
   localparam int PP_W    = COEF_W + DIG_W;

   // Elaboration-time parameter checks
   if (DATA_W % DIG_W != 0) begin : g_chk_slice
      $error("DATA_W must be a whole number of digits");
   end
   if (DIG_W < 2 || DIG_W > 6) begin : g_chk_dig
      $error("DIG_W must lie in 2..6");
   end
   if (COEF_W < 2 || DATA_W + COEF_W > 62) begin : g_chk_prod
      $error("product width out of range");
   end

   logic [COEF_W-1:0]            coef_q;
   logic signed [PP_W-1:0]       tbl [TBL_N];
   logic                         accept;
   logic                         pp_valid;
   logic [NUM_DIG-1:0][PP_W-1:0] pp;

   assign accept = in_valid & ~busy;

   slc_table_fill #(.COEF_W(COEF_W), .DIG_W(DIG_W)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .coef_load (coef_load),
      .coef_in   (coef_in),
      .busy      (busy),
      .coef_q    (coef_q),
      .tbl       (tbl)
   );

   slc_digit_lut #(.DATA_W(DATA_W), .COEF_W(COEF_W), .DIG_W(DIG_W)) u_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .in_data  (in_data),
      .coef_q   (coef_q),
      .tbl      (tbl),
      .pp_valid (pp_valid),
      .pp       (pp)
   );

   slc_sum_round #(.DATA_W(DATA_W), .COEF_W(COEF_W), .DIG_W(DIG_W)) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .pp_valid  (pp_valid),
      .pp        (pp),
      .out_valid (out_valid),
      .out_prod  (out_prod)
   );
endmodule

// File: rtl/slc_checks.sv
module slc_checks #(
   parameter int DATA_W = 16,
   parameter int DIG_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coef_load,
   input logic              busy,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_prod
);
   localparam int TBL_N = 1 << DIG_W;

   logic [1:0]  age;
   logic [15:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= '0;
         run <= '0;
      end else begin
         if (age != 2'd3) age <= age + 2'd1;
         if (coef_load)   run <= '0;
         else if (busy)   run <= run + 16'd1;
      end
   end

   // R4 (with R3): a result appears exactly three cycles after an accepted word
   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid && !busy, 3)));

   // R2: busy only starts after a load pulse
   assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(coef_load));

   // R2, R8: busy ends exactly TBL_N cycles after the last load
   assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == 16'(TBL_N)));

   // R9: the result holds while no new one is flagged
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !out_valid) |-> $stable(out_prod));
endmodule

bind slice_const_mul slc_checks #(.DATA_W(DATA_W), .DIG_W(DIG_W)) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .coef_load (coef_load),
   .busy      (busy),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_prod  (out_prod)
);

// File: tb/tb_slice_const_mul.sv
module tb_slice_const_mul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        coef_load = 1'b0;
   logic [15:0] coef_in = '0;
   logic        busy;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_prod;

   always #10 clk = ~clk;   // 50 MHz

   slice_const_mul dut (
      .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_in(coef_in),
      .busy(busy), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_prod(out_prod)
   );

   typedef struct {
      logic [15:0] val;
      int          due;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;
   logic [15:0] last_out = '0;
   logic [15:0] cur_coef = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] ref_mul(logic [15:0] d, logic [15:0] c);
      longint p;
      p = longint'($signed(d)) * longint'($signed(c));
      p = (p + 64'sd16384) >>> 15;
      if (p > 64'sd32767)  p = 64'sd32767;
      if (p < -64'sd32768) p = -64'sd32768;
      return p[15:0];
   endfunction

   task automatic check(bit ok, string tag, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   // Driver: one word per call, expected result queued when it will be accepted
   task automatic send(logic [15:0] d, string tag);
      in_valid = 1'b1;
      in_data  = d;
      sb.push_back('{ref_mul(d, cur_coef), cyc + 3, tag});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Load pulse and R2 busy check; optional probing words during fill (R3)
   // and an optional word in the load cycle (R10)
   task automatic load(logic [15:0] c, bit probe, bit same_cyc, logic [15:0] sd);
      coef_load = 1'b1;
      coef_in   = c;
      if (same_cyc) begin
         in_valid = 1'b1;
         in_data  = sd;
         sb.push_back('{ref_mul(sd, cur_coef), cyc + 3, "R10 old coefficient"});
      end
      @(negedge clk);
      coef_load = 1'b0;
      in_valid  = 1'b0;
      cur_coef  = c;
      for (int i = 0; i < 16; i++) begin
         check(busy === 1'b1, "R2 busy during fill", busy, 1);
         if (probe) begin
            in_valid = 1'b1;
            in_data  = 16'h1111 * 16'(i + 1);
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
      check(busy === 1'b0, "R2 busy clears after 16", busy, 0);
   endtask

   task automatic drain;
      int t;
      t = 0;
      while (sb.size() != 0 && t < 50) begin
         @(negedge clk);
         t++;
      end
      check(sb.size() == 0, "R4 results delivered", sb.size(), 0);
      idle(4);
   endtask

   // Monitor: compares results against the scoreboard
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (out_valid === 1'b1) begin
            if (sb.size() == 0) begin
               check(1'b0, "R3 unexpected result", out_prod, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(cyc == e.due, {e.tag, " / R4 timing"}, cyc, e.due);
               check(out_prod === e.val, e.tag, out_prod, e.val);
            end
            last_out = out_prod;
         end else begin
            check(out_prod === last_out, "R9 hold", out_prod, last_out);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy === 1'b0, "R1 busy at reset", busy, 0);
      check(out_valid === 1'b0, "R1 out_valid at reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      // R1: empty table gives zero
      send(16'h4000, "R1 zero table");
      send(16'h8000, "R1 zero table");
      send(16'hFFFF, "R1 zero table");
      drain();

      // Coefficient 0.5 with words driven during the fill (R3 must drop them)
      load(16'h4000, 1'b1, 1'b0, 16'h0);
      drain();
      send(16'h4000, "R5 half times half");
      send(16'h7FFF, "R5 max positive");
      send(16'h0001, "R5 round up");
      send(16'h8000, "R6 top digit -1");
      send(16'hFFFF, "R6 all ones");
      send(16'hF000, "R6 top digit only");
      drain();

      // Coefficient -1: saturation corner
      load(16'h8000, 1'b0, 1'b0, 16'h0);
      send(16'h8000, "R7 minus one squared");
      send(16'h7FFF, "R5 coef minus one");
      send(16'h1234, "R5 coef minus one");
      send(16'h8001, "R6 near minus one");
      drain();

      // R8: reload during a fill restarts it
      coef_load = 1'b1;
      coef_in   = 16'h6A3C;
      @(negedge clk);
      coef_load = 1'b0;
      for (int i = 0; i < 5; i++) begin
         check(busy === 1'b1, "R8 busy before restart", busy, 1);
         @(negedge clk);
      end
      load(16'hC5B1, 1'b0, 1'b0, 16'h0);
      // Every digit value in every position
      for (int v = 0; v < 16; v++) begin
         send(16'(v * 16'h1111), "R8 new coefficient");
      end
      drain();

      // R10: word in the load cycle uses the previous coefficient
      load(16'h2D4F, 1'b0, 1'b1, 16'h9ABC);
      drain();
      send(16'h9ABC, "R10 new coefficient after fill");
      drain();

      // Mixed stream under several coefficients
      for (int r = 0; r < 3; r++) begin
         load(16'(16'h3C5A * (r + 3)), 1'b0, 1'b0, 16'h0);
         for (int i = 0; i < 30; i++) begin
            send(16'((i * 16'h9E37) ^ (r * 16'h5A5A) ^ (i << 11)), "R5 stream");
         end
         drain();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule